// File: doc/BRIEF.md
# Interrupt Cycle Controller

This block handles interrupt entry for a small accumulator machine whose datapath is stepped by an external sequence counter. It holds three pieces of state. The interrupt-enable flag is set and cleared by program commands. The interrupt-cycle flag records that a device request has been accepted. A temporary register keeps the return address while it is being stored.

While the interrupt-cycle flag is clear, the block passes the three normal fetch steps to the datapath. These are loading the address register from the program counter, loading the instruction and incrementing the program counter, and decoding. While the flag is set, the block blocks those three steps and runs a three-step entry sequence in their place. The sequence stores the interrupted program counter in memory word 0, points the program counter at word 1 and turns interrupts off.

The block has no datapath of its own. It drives control strobes into the address register, the program counter, the memory write port and the sequence counter clear. It also supplies the write data from its temporary register.

Top module: `intr_cycle_ctl`

## Requirements
- R1: When the interrupt-cycle flag is 1 at step 0 (t_step == 4'b0001), ar_clr and tr_ld are 1. At that clock edge the temporary register takes the zero-extended pc_in.
- R2: When the interrupt-cycle flag is 1 at step 1 (t_step == 4'b0010), mem_wr and pc_clr are 1, and the write data on tr_q is the value captured at step 0.
- R3: When the interrupt-cycle flag is 1 at step 2 (t_step == 4'b0100), pc_inc and sc_clr are 1. At that edge both the interrupt-cycle flag and the enable flag become 0.
- R4: The fetch strobes are enabled only while the interrupt-cycle flag is 0: ar_ld_pc at step 0, ir_ld and pc_inc at step 1, and dec_en at step 2. While the flag is 1, none of them is active.
- R5: The interrupt-cycle flag becomes 1 at a clock edge only when none of steps 0, 1 or 2 is active, the enable flag is 1, and in_flag or out_flag is 1. The enable flag is the value it holds before that edge.
- R6: ien_on and ien_off act only at step 3 (t_step == 4'b1000). When both are given at that step, ien_off wins. At any other step they are ignored.
- R7: A request that arrives while the enable flag is 0 does not set the interrupt-cycle flag. It is taken after the enable flag is set, provided the device flag is still held.
- R8: Synchronous active-high reset clears the enable flag, the interrupt-cycle flag and the temporary register.
- R9: After a complete entry sequence, memory word 0 holds the interrupted program counter, the program counter is 1 and ien_q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_step | input | 4 | One-hot timing steps 0..3 from the sequence counter; all zero at later steps |
| in_flag | input | 1 | Input device ready flag |
| out_flag | input | 1 | Output device ready flag |
| ien_on | input | 1 | Interrupt-enable set command (honoured at step 3) |
| ien_off | input | 1 | Interrupt-enable clear command (honoured at step 3) |
| pc_in | input | AW | Current program counter |
| ar_clr | output | 1 | Clear the address register |
| ar_ld_pc | output | 1 | Load the address register from the program counter (fetch) |
| tr_ld | output | 1 | Temporary register loads the program counter this cycle |
| tr_q | output | DW | Temporary register, used as memory write data |
| mem_wr | output | 1 | Memory write strobe |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| ir_ld | output | 1 | Instruction register load / memory read (fetch) |
| dec_en | output | 1 | Decode step enable (fetch) |
| sc_clr | output | 1 | Clear the sequence counter |
| ien_q | output | 1 | Interrupt-enable flag |
| icyc_q | output | 1 | Interrupt-cycle flag |

## Verification
At step 3, a disable command and a held device request can act at the same clock edge. The enable flag drops, and the cycle flag is still taken because it sees the enable value from before the edge. The bench runs this case by raising in_flag and ien_off together at step 3 with interrupts on. The bench's behavioural model predicts both flag values after the edge and the full entry sequence that follows. A second collision drives ien_on and ien_off at the same step; the bench judges it by the enable flag read back one cycle later.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int STEPS = 4;
  localparam int S_T0 = 0;
  localparam int S_T1 = 1;
  localparam int S_T2 = 2;
  localparam int S_T3 = 3;

  typedef struct packed {
    logic ar_clr;
    logic ar_ld_pc;
    logic tr_ld;
    logic mem_wr;
    logic pc_clr;
    logic pc_inc;
    logic ir_ld;
    logic dec_en;
    logic sc_clr;
  } icc_ctl_t;
endpackage

// File: rtl/icc_enable.sv
module icc_enable (
  input  logic clk,
  input  logic rst,
  input  logic at_t3,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic entry_done,
  output logic ien_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
    end else if (entry_done) begin
      ien_q <= 1'b0;
    end else if (at_t3) begin
      if (cmd_off) begin
        ien_q <= 1'b0;
      end else if (cmd_on) begin
        ien_q <= 1'b1;
      end
    end
  end

  // R6: a rise needs an on command at step 3 with no off command
  assert_ien_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ien_q) |-> $past(at_t3 && cmd_on && !cmd_off));
  // R3 / R6: a fall comes only from an off command at step 3 or the end of entry
  assert_ien_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ien_q) |-> $past((at_t3 && cmd_off) || entry_done));
endmodule

// File: rtl/icc_cycle_flag.sv
module icc_cycle_flag (
  input  logic clk,
  input  logic rst,
  input  logic fetch_window,
  input  logic at_t2,
  input  logic ien,
  input  logic request,
  output logic icyc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      icyc_q <= 1'b0;
    end else if (icyc_q && at_t2) begin
      icyc_q <= 1'b0;
    end else if (!fetch_window && ien && request) begin
      icyc_q <= 1'b1;
    end
  end

  // R5: the flag is taken only outside steps 0..2 with enable and a request
  assert_take_cond_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(icyc_q) |-> $past(!fetch_window && ien && request));
  // R3: the flag leaves only at step 2 of the entry sequence
  assert_leave_t2_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(icyc_q) |-> $past(at_t2));
  // R7: with enable low the flag never rises
  assert_no_take_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!ien && !icyc_q) |=> !icyc_q);
endmodule

// File: rtl/icc_tr_reg.sv
module icc_tr_reg #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] pc,
  output logic [DW-1:0] tr_q
);
  logic [DW-1:0] pc_ext;
  assign pc_ext = DW'(pc);

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_q <= '0;
    end else if (ld) begin
      tr_q <= pc_ext;
    end
  end

  // R1: the register holds the program counter captured at step 0
  assert_tr_capture_R1: assert property (@(posedge clk) disable iff (rst)
    ld |=> (tr_q == $past(pc_ext)));
  // R2: without a load the stored return address does not move
  assert_tr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(tr_q));
endmodule

// File: rtl/icc_strobes.sv
module icc_strobes
  import icc_pkg::*;
(
  input  logic             icyc,
  input  logic [STEPS-1:0] t_step,
  output icc_ctl_t         ctl
);
  logic t0, t1, t2;
  assign t0 = t_step[S_T0];
  assign t1 = t_step[S_T1];
  assign t2 = t_step[S_T2];

  always_comb begin
    ctl          = '0;
    ctl.ar_ld_pc = !icyc && t0;
    ctl.ir_ld    = !icyc && t1;
    ctl.dec_en   = !icyc && t2;
    ctl.ar_clr   = icyc && t0;
    ctl.tr_ld    = icyc && t0;
    ctl.mem_wr   = icyc && t1;
    ctl.pc_clr   = icyc && t1;
    ctl.sc_clr   = icyc && t2;
    ctl.pc_inc   = (!icyc && t1) || (icyc && t2);
  end
endmodule

// File: rtl/intr_cycle_ctl.sv
module intr_cycle_ctl
  import icc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STEPS-1:0] t_step,
  input  logic             in_flag,
  input  logic             out_flag,
  input  logic             ien_on,
  input  logic             ien_off,
  input  logic [AW-1:0]    pc_in,
  output logic             ar_clr,
  output logic             ar_ld_pc,
  output logic             tr_ld,
  output logic [DW-1:0]    tr_q,
  output logic             mem_wr,
  output logic             pc_clr,
  output logic             pc_inc,
  output logic             ir_ld,
  output logic             dec_en,
  output logic             sc_clr,
  output logic             ien_q,
  output logic             icyc_q
);
  icc_ctl_t ctl;
  logic     fetch_window;

  assign fetch_window = t_step[S_T0] | t_step[S_T1] | t_step[S_T2];

  icc_strobes u_strobes (
    .icyc   (icyc_q),
    .t_step (t_step),
    .ctl    (ctl)
  );

  icc_enable u_enable (
    .clk        (clk),
    .rst        (rst),
    .at_t3      (t_step[S_T3]),
    .cmd_on     (ien_on),
    .cmd_off    (ien_off),
    .entry_done (ctl.sc_clr),
    .ien_q      (ien_q)
  );

  icc_cycle_flag u_flag (
    .clk          (clk),
    .rst          (rst),
    .fetch_window (fetch_window),
    .at_t2        (t_step[S_T2]),
    .ien          (ien_q),
    .request      (in_flag | out_flag),
    .icyc_q       (icyc_q)
  );

  icc_tr_reg #(.AW(AW), .DW(DW)) u_tr (
    .clk  (clk),
    .rst  (rst),
    .ld   (ctl.tr_ld),
    .pc   (pc_in),
    .tr_q (tr_q)
  );

  assign ar_clr   = ctl.ar_clr;
  assign ar_ld_pc = ctl.ar_ld_pc;
  assign tr_ld    = ctl.tr_ld;
  assign mem_wr   = ctl.mem_wr;
  assign pc_clr   = ctl.pc_clr;
  assign pc_inc   = ctl.pc_inc;
  assign ir_ld    = ctl.ir_ld;
  assign dec_en   = ctl.dec_en;
  assign sc_clr   = ctl.sc_clr;

  // R2: the memory write of the entry sequence follows the capture step
  assert_wr_after_cap_R2: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(tr_ld));
  // R3: after the sequence counter clear, both flags are off
  assert_exit_flags_R3: assert property (@(posedge clk) disable iff (rst)
    sc_clr |=> (!icyc_q && !ien_q));
  // R4: a fetch strobe and an entry strobe never share a cycle
  assert_fetch_excl_R4: assert property (@(posedge clk) disable iff (rst)
    (ar_ld_pc || ir_ld || dec_en) |-> !(ar_clr || mem_wr || sc_clr));
  // timing steps are one-hot or idle
  assert_step_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(t_step));
endmodule

// File: tb/sim_intr_cycle_ctl.sv
module sim_intr_cycle_ctl;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0]    tstep;
  logic          fgi = 1'b0, fgo = 1'b0, ion = 1'b0, iof = 1'b0;
  logic [AW-1:0] pc;
  logic          ar_clr, ar_ld_pc, tr_ld, mem_wr, pc_clr, pc_inc;
  logic          ir_ld, dec_en, sc_clr, ien_q, icyc_q;
  logic [DW-1:0] tr_q;

  intr_cycle_ctl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .t_step(tstep), .in_flag(fgi), .out_flag(fgo),
    .ien_on(ion), .ien_off(iof), .pc_in(pc), .ar_clr(ar_clr),
    .ar_ld_pc(ar_ld_pc), .tr_ld(tr_ld), .tr_q(tr_q), .mem_wr(mem_wr),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .ir_ld(ir_ld), .dec_en(dec_en),
    .sc_clr(sc_clr), .ien_q(ien_q), .icyc_q(icyc_q)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // datapath environment: sequence counter, PC, AR, memory
  logic [2:0]    sc;
  logic [AW-1:0] ar;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always_comb tstep = (sc < 3'd4) ? (4'b0001 << sc) : 4'b0000;

  always @(posedge clk) begin
    if (rst) begin
      sc <= 3'd0;
      pc <= 12'h120;
      ar <= '0;
    end else begin
      if (sc_clr || sc == 3'd4) sc <= 3'd0;
      else sc <= sc + 3'd1;
      if (pc_clr) pc <= '0;
      else if (pc_inc) pc <= pc + 1'b1;
      if (ar_clr) ar <= '0;
      else if (ar_ld_pc) ar <= pc;
      if (mem_wr) mem[ar] <= tr_q;
    end
  end

  // behavioural reference model of the flags and the temporary register
  logic          m_ien, m_r;
  logic [DW-1:0] m_tr;
  always @(posedge clk) begin
    if (rst) begin
      m_ien <= 1'b0;
      m_r   <= 1'b0;
      m_tr  <= '0;
    end else begin
      if (m_r && sc == 3'd2) begin
        m_r   <= 1'b0;
        m_ien <= 1'b0;
      end else begin
        if (sc > 3'd2 && m_ien && (fgi || fgo)) m_r <= 1'b1;
        if (sc == 3'd3) begin
          if (iof) m_ien <= 1'b0;
          else if (ion) m_ien <= 1'b1;
        end
      end
      if (m_r && sc == 3'd0) m_tr <= DW'(pc);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R6", "ien_q", 32'(ien_q), 32'(m_ien));
      chk("R5", "icyc_q", 32'(icyc_q), 32'(m_r));
      chk("R1", "tr_q", 32'(tr_q), 32'(m_tr));
      chk("R1", "ar_clr", 32'(ar_clr), 32'(m_r && sc == 3'd0));
      chk("R1", "tr_ld", 32'(tr_ld), 32'(m_r && sc == 3'd0));
      chk("R2", "mem_wr", 32'(mem_wr), 32'(m_r && sc == 3'd1));
      chk("R2", "pc_clr", 32'(pc_clr), 32'(m_r && sc == 3'd1));
      chk("R3", "sc_clr", 32'(sc_clr), 32'(m_r && sc == 3'd2));
      chk("R3", "pc_inc", 32'(pc_inc),
          32'((!m_r && sc == 3'd1) || (m_r && sc == 3'd2)));
      chk("R4", "ar_ld_pc", 32'(ar_ld_pc), 32'(!m_r && sc == 3'd0));
      chk("R4", "ir_ld", 32'(ir_ld), 32'(!m_r && sc == 3'd1));
      chk("R4", "dec_en", 32'(dec_en), 32'(!m_r && sc == 3'd2));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic goto_step(input logic [2:0] s);
    do begin
      @(posedge clk); #2;
    end while (sc != s);
  endtask

  task automatic pulse_cmd(input logic on, input logic off);
    ion = on; iof = off;
    @(posedge clk); #2;
    ion = 1'b0; iof = 1'b0;
  endtask

  logic [AW-1:0] saved;

  task automatic run_entry(input string tag);
    while (!icyc_q) begin
      @(posedge clk); #2;
    end
    saved = pc;
    while (icyc_q) begin
      @(posedge clk); #2;
    end
    chk(tag, "mem[0]", 32'(mem[0]), 32'(saved));
    chk(tag, "pc after entry", 32'(pc), 32'd1);
    chk(tag, "ien after entry", 32'(ien_q), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    mem[0] = 16'hDEAD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset ien_q", 32'(ien_q), 32'd0);
    chk("R8", "reset icyc_q", 32'(icyc_q), 32'd0);
    chk("R8", "reset tr_q", 32'(tr_q), 32'd0);
    @(posedge clk); #2;
    rst = 1'b0;

    // R7: request held while interrupts are off is not taken
    fgi = 1'b1;
    repeat (30) @(posedge clk);
    #2;
    chk("R7", "no entry while ien off", 32'(icyc_q), 32'd0);
    goto_step(3'd3);
    pulse_cmd(1'b1, 1'b0);
    chk("R7", "ien set by on command", 32'(ien_q), 32'd1);
    run_entry("R9");
    fgi = 1'b0;

    // output-flag request path
    repeat (7) @(posedge clk);
    #2;
    fgo = 1'b1;
    goto_step(3'd3);
    pulse_cmd(1'b1, 1'b0);
    run_entry("R9");
    fgo = 1'b0;

    // R6: off wins over on at step 3
    goto_step(3'd3);
    pulse_cmd(1'b1, 1'b0);
    goto_step(3'd3);
    pulse_cmd(1'b1, 1'b1);
    chk("R6", "off wins", 32'(ien_q), 32'd0);

    // R6: commands outside step 3 are ignored
    goto_step(3'd4);
    pulse_cmd(1'b1, 1'b0);
    chk("R6", "on at step 4 ignored", 32'(ien_q), 32'd0);
    goto_step(3'd1);
    pulse_cmd(1'b1, 1'b0);
    chk("R6", "on at step 1 ignored", 32'(ien_q), 32'd0);
    goto_step(3'd3);
    pulse_cmd(1'b1, 1'b0);
    goto_step(3'd2);
    pulse_cmd(1'b0, 1'b1);
    chk("R6", "off at step 2 ignored", 32'(ien_q), 32'd1);

    // R5: a request during steps 0..2 waits until step 3
    goto_step(3'd0);
    fgi = 1'b1;
    goto_step(3'd2);
    chk("R5", "no take in fetch window", 32'(icyc_q), 32'd0);
    @(posedge clk); #2;
    chk("R5", "no take at step 2 edge", 32'(icyc_q), 32'd0);
    @(posedge clk); #2;
    chk("R5", "taken at step 3 edge", 32'(icyc_q), 32'd1);
    run_entry("R9");
    fgi = 1'b0;

    // same edge: off command and request at step 3 with ien on
    goto_step(3'd3);
    pulse_cmd(1'b1, 1'b0);
    goto_step(3'd3);
    fgi = 1'b1;
    pulse_cmd(1'b0, 1'b1);
    chk("R5", "taken with prior ien", 32'(icyc_q), 32'd1);
    chk("R6", "ien off same edge", 32'(ien_q), 32'd0);
    run_entry("R9");
    fgi = 1'b0;

    repeat (10) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule